// File: doc/BRIEF.md
# Ten-Bit Serializer with Comma Fill

This block serializes characters that the user has already encoded in ten-bit form. Each character is accepted once per word slot and sent out one bit per bit-clock cycle, most significant position first. A divide-by-ten counter inside the block marks the word slots and drives a one-cycle word strobe. The input side is qualified by two active-low enables; if either one is low at a word slot, the user character is taken.

When both enables are high at a word slot, the block substitutes a K28.5 comma so that the far end keeps its character alignment. The commas it inserts alternate between their two running-disparity forms. User characters are not inspected, so the polarity of the first comma after user data may not be correct, but every comma after that one is. The serial stream is copied onto several identical output lanes, each of which can drive a separate link.

A character passes through an input register and then a shifter. The input register captures it at one word strobe, and the shifter loads it at the next word strobe. It is therefore sent in the word slot that follows the one after it was offered.

Top module: `ser10_pad_tx`

## Requirements
- R1: Within a character, bit `data_in[9]` (position a) leaves first and `data_in[0]` (position j) leaves last, one bit per clock cycle.
- R2: `word_stb` is high for exactly one cycle in every ten. After reset is released, the first high cycle is the tenth cycle (cycle index 9).
- R3: At a word strobe, if `en_a_n` or `en_b_n` is low, the value on `data_in` is captured unchanged. Inputs have no effect in cycles without a strobe.
- R4: A character captured at word strobe k is sent during the ten cycles that follow word strobe k+1.
- R5: At a word strobe with both enables high, a comma is captured instead of `data_in`. The comma is 10'b0011111010 (bit 9 = a) for negative running disparity and 10'b1100000101 for positive running disparity.
- R6: Each inserted comma flips the running disparity that selects the next comma. Captured user characters leave it unchanged, so back-to-back commas alternate between the two forms.
- R7: Synchronous active-high `rst` clears the shifter, so the outputs are low until the first word strobe. It also loads the negative-disparity comma into the input register, so that comma is sent in the second word slot. The next inserted comma uses the positive form.
- R8: All `ser_out` lanes carry the same bit in every cycle.
- R9: While `en_a_n` is held low, no comma is ever inserted and every slot carries user data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 10 | Pre-encoded character; bit 9 is position a |
| en_a_n | input | 1 | Active-low enable, first of two |
| en_b_n | input | 1 | Active-low enable, second of two |
| ser_out | output | 3 | Identical serial output lanes |
| word_stb | output | 1 | High in the cycle that ends each word slot |

## Verification
Inputs are applied during the cycle in which `word_stb` is high, and they take effect at the next rising edge. The bench holds an expected input-register value and an expected shifter value. It moves both on at every strobe edge, so a character is expected on the lanes in the ten cycles after the following strobe, and bit k of those ten is expected in the k-th cycle. All outputs are sampled on the falling edge, so every sample falls in the middle of the cycle to which it belongs. The strobe period is checked in every cycle against a cycle count that starts at reset release.

// File: rtl/ser10_pkg.sv
package ser10_pkg;
    localparam int CHAR_W = 10;

    typedef logic [CHAR_W-1:0] char_t;

    // comma forms, bit CHAR_W-1 is sent first
    localparam char_t COMMA_NEG = 10'b0011111010;
    localparam char_t COMMA_POS = 10'b1100000101;

    function automatic char_t comma_for(input logic rd_pos);
        return rd_pos ? COMMA_POS : COMMA_NEG;
    endfunction
endpackage

// File: rtl/ser10_word_timer.sv
module ser10_word_timer #(
    parameter int RATIO = 10
) (
    input  logic clk,
    input  logic rst,
    output logic word_stb
);
    localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_stb = (st_q.cnt == LAST);

    p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> !word_stb);
endmodule

// File: rtl/ser10_char_select.sv
module ser10_char_select
    import ser10_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  word_stb,
    input  char_t data_in,
    input  logic  en_a_n,
    input  logic  en_b_n,
    output char_t char_q
);
    typedef struct packed {
        char_t hold;
        logic  rd_pos;
    } sel_t;

    sel_t st_d, st_q;
    logic en_any;

    assign en_any = !en_a_n || !en_b_n;

    always_comb begin
        st_d = st_q;
        if (word_stb) begin
            if (en_any) begin
                st_d.hold = data_in;
            end else begin
                st_d.hold   = comma_for(st_q.rd_pos);
                st_d.rd_pos = !st_q.rd_pos;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.hold   <= COMMA_NEG;
            st_q.rd_pos <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign char_q = st_q.hold;

    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (word_stb && en_any) |=> (st_q.hold == $past(data_in)));

    p_comma_form_r5: assert property (@(posedge clk) disable iff (rst)
        (word_stb && !en_any) |=> (st_q.hold == COMMA_NEG || st_q.hold == COMMA_POS));

    p_rd_flip_r6: assert property (@(posedge clk) disable iff (rst)
        (word_stb && !en_any) |=> (st_q.rd_pos != $past(st_q.rd_pos)));

    p_rd_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (word_stb && en_any) |=> $stable(st_q.rd_pos));

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !word_stb |=> $stable(st_q.hold));
endmodule

// File: rtl/ser10_shifter.sv
module ser10_shifter
    import ser10_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  word_stb,
    input  char_t char_in,
    output logic  bit_out
);
    typedef struct packed {
        char_t sh;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (word_stb) begin
            st_d.sh = char_in;
        end else begin
            st_d.sh = {st_q.sh[CHAR_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_out = st_q.sh[CHAR_W-1];

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> (st_q.sh == $past(char_in)));
endmodule

// File: rtl/ser10_pad_tx.sv
module ser10_pad_tx
    import ser10_pkg::*;
#(
    parameter int N_LANES = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CHAR_W-1:0]  data_in,
    input  logic               en_a_n,
    input  logic               en_b_n,
    output logic [N_LANES-1:0] ser_out,
    output logic               word_stb
);
    char_t held_char;
    logic  tx_bit;

    ser10_word_timer #(.RATIO(CHAR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .word_stb (word_stb)
    );

    ser10_char_select u_select (
        .clk      (clk),
        .rst      (rst),
        .word_stb (word_stb),
        .data_in  (data_in),
        .en_a_n   (en_a_n),
        .en_b_n   (en_b_n),
        .char_q   (held_char)
    );

    ser10_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .word_stb (word_stb),
        .char_in  (held_char),
        .bit_out  (tx_bit)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign ser_out[g] = tx_bit;
    end

    p_low_after_reset_r7: assert property (@(posedge clk)
        rst |=> (ser_out == '0));
endmodule

// File: tb/tb_ser10_pad_tx.sv
module tb_ser10_pad_tx;
    localparam int CLK_P   = 10;
    localparam int N_WORDS = 64;

    localparam logic [9:0] C_NEG = 10'b0011111010;
    localparam logic [9:0] C_POS = 10'b1100000101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] data_in = '0;
    logic       en_a_n = 1'b1;
    logic       en_b_n = 1'b1;
    logic [2:0] ser_out;
    logic       word_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    ser10_pad_tx dut (
        .clk      (clk),
        .rst      (rst),
        .data_in  (data_in),
        .en_a_n   (en_a_n),
        .en_b_n   (en_b_n),
        .ser_out  (ser_out),
        .word_stb (word_stb)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [9:0] comma_exp(input bit rd_pos);
        return rd_pos ? C_POS : C_NEG;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [9:0] cur, pend, nxt;
        string      cur_tag, pend_tag, nxt_tag;
        int         bitidx, cyc, word;
        bit         rd_pos;
        int unsigned seed;

        seed = $urandom(32'd20240611);
        cur = '0;       cur_tag  = "R7 pre-strobe low";
        pend = C_NEG;   pend_tag = "R7 reset comma";
        rd_pos = 1'b1;
        bitidx = 0; cyc = 0; word = 0;

        repeat (3) @(negedge clk);
        chk("R7 reset output", 32'(ser_out), 32'd0);
        chk("R2 reset strobe", 32'(word_stb), 32'd0);
        rst = 1'b0;

        while (word < N_WORDS) begin
            // checks for this cycle
            chk(cur_tag, 32'(ser_out), {29'd0, {3{cur[9-bitidx]}}});
            chk("R8 lanes equal", 32'(ser_out == {3{ser_out[0]}}), 32'd1);
            chk("R2 strobe period", 32'(word_stb), 32'((cyc % 10) == 9));

            if (word_stb) begin
                // choose stimulus for this word slot
                if (word < 6 || (word >= 41 && word < 47)) begin
                    en_a_n = 1'b1; en_b_n = 1'b1;          // idle run: R6
                    data_in = 10'($urandom);
                end else if (word >= 31 && word < 41) begin
                    en_a_n = 1'b0; en_b_n = 1'($urandom);   // R9
                    data_in = 10'($urandom);
                end else if (word == 6) begin
                    en_a_n = 1'b0; en_b_n = 1'b1; data_in = 10'h3FF;
                end else if (word == 7) begin
                    en_a_n = 1'b1; en_b_n = 1'b0; data_in = 10'h200;
                end else if (word == 8) begin
                    en_a_n = 1'b0; en_b_n = 1'b0; data_in = 10'h001;
                end else begin
                    en_a_n = 1'($urandom); en_b_n = 1'($urandom);
                    data_in = 10'($urandom);
                end

                if (!en_a_n || !en_b_n) begin
                    nxt = data_in;
                    nxt_tag = (word >= 31 && word < 41) ? "R9 data only" : "R3/R1/R4 data";
                end else begin
                    nxt = comma_exp(rd_pos);
                    nxt_tag = rd_pos ? "R5/R6 comma pos" : "R5/R6 comma neg";
                    rd_pos = !rd_pos;
                end
                cur = pend; cur_tag = pend_tag;
                pend = nxt; pend_tag = nxt_tag;
                bitidx = 0;
                word++;
            end else begin
                bitidx = (bitidx < 9) ? bitidx + 1 : 9;
                // inputs between strobes must be ignored (R3)
                data_in = 10'($urandom);
                en_a_n = 1'($urandom);
                en_b_n = 1'($urandom);
            end
            cyc++;
            @(negedge clk);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule